// File: doc/BRIEF.md
# Saturating Ramp Generator with Limit Snap-Back

This block produces a 32-bit control word for a direct digital synthesizer. The word climbs or descends between a programmable floor and ceiling. The upward and downward increments are set separately. A prescaler divides the system clock by four to make a ramp tick. A programmable interval count then decides how many ticks pass between two steps. The accumulator never wraps. A step that would cross a limit lands exactly on that limit. A per-limit no-dwell control then chooses what happens next. The ramp either turns round, or on the following step snaps back to the opposite limit, which gives a continuous sawtooth.

A destination select sends the word to the frequency-offset output or to the phase-offset output. The unused output is held at zero. In phase mode only the top 16 bits of each limit are used, and the lower 16 bits are forced to zero. With the floor at zero, the ceiling at its maximum, both no-dwell controls set and a power-of-two increment, the phase offset runs as a sawtooth. This acts as an extra fine frequency offset.

The direction is held in a two-state machine. RISE means the next step adds the upward increment. FALL means the next step subtracts the downward increment. The transitions are:
- RISE to FALL when a rising step clamps at the ceiling and ceiling no-dwell is clear.
- FALL to RISE when a falling step clamps at the floor and floor no-dwell is clear.
- Either state to the level of the direction input when a pending direction change is applied at a step instant, or when a synchronous clear is given.
- RISE stays RISE when it snaps from the ceiling to the floor, and FALL stays FALL when it snaps from the floor to the ceiling.

Top module: `dig_ramp_gen`

## Requirements
- R1: After the asynchronous reset, the ramp word, both offsets and both limit flags are zero. A synchronous clear loads the floor into the ramp word, restarts the prescaler and the interval counter, clears both flags, and sets the direction from the direction input.
- R2: A step is taken on every ramp tick (one clock in four) at which the interval counter has completed `interval` ticks. An interval of 0 behaves like 1. Between steps the ramp word does not change.
- R3: In RISE a step adds `step_up`, and in FALL a step subtracts `step_dn`. The two increments are independent.
- R4: The accumulator never wraps modulo 2^32. A rising step whose sum is at or above the ceiling, including a carry out of bit 31, yields exactly the ceiling. A falling step whose result is at or below the floor, including a borrow, yields exactly the floor.
- R5: With `nodwell_hi` = 0, clamping at the ceiling turns the state to FALL. With `nodwell_lo` = 0, clamping at the floor turns the state to RISE.
- R6: With `nodwell_hi` = 1, a rising step taken while the word is at or above the ceiling loads the floor and stays in RISE. With `nodwell_lo` = 1, a falling step taken while the word is at or below the floor loads the ceiling and stays in FALL.
- R7: Any change of `dir_up` (1 = RISE, 0 = FALL) resets the interval counter at once and suppresses a step in that clock. The new direction is used from the next step instant onward.
- R8: With `dest_phase` = 1, the limits used are the inputs with bits 15:0 forced to zero, `phase_ofs` carries the ramp word and `freq_ofs` is zero. With `dest_phase` = 0, the limits are used in full, `freq_ofs` carries the ramp word and `phase_ofs` is zero.
- R9: `at_hi` (or `at_lo`) goes high for exactly one ramp tick (four clocks) after a step that leaves the word on the ceiling (or the floor), counting snaps. It is low after any tick without such a step.
- R10: With both no-dwell controls clear and `step_dn` = 2^32 − `step_up`, a ramp whose ceiling is a multiple of `step_up` drops from the ceiling to the floor in one step and then rises again, forming a sawtooth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| dir_up | input | 1 | Requested direction, 1 = rising |
| dest_phase | input | 1 | Destination select, 1 = phase offset |
| nodwell_hi | input | 1 | Snap back from the ceiling instead of reversing |
| nodwell_lo | input | 1 | Snap back from the floor instead of reversing |
| lim_hi | input | 32 | Ceiling |
| lim_lo | input | 32 | Floor |
| step_up | input | 32 | Rising increment |
| step_dn | input | 32 | Falling decrement |
| interval | input | 16 | Ramp ticks per step (0 acts as 1) |
| ramp_out | output | 32 | Ramp accumulator |
| freq_ofs | output | 32 | Frequency offset contribution |
| phase_ofs | output | 32 | Phase offset contribution |
| at_hi | output | 1 | Ceiling reached, one tick long |
| at_lo | output | 1 | Floor reached, one tick long |

## Verification
Slow in-range ramps with different increments and intervals, including an interval of zero, show the step cadence and confirm that the rise and fall increments stay apart. Large increments near the ceiling and a sum that carries out of 32 bits separate exact clamping from wrap-around. Runs with each combination of no-dwell controls tell reversal apart from snap-back. Direction toggles in the middle of an interval expose counter reload and deferred application. Phase-mode runs with full-scale limits, and a triangle run with complementary increments, cover limit masking, output routing and the emulated sawtooth.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef enum logic {
        DR_RISE = 1'b0,
        DR_FALL = 1'b1
    } dr_dir_e;
endpackage

// File: rtl/dr_tick_gen.sv
module dr_tick_gen #(
    parameter int TICK_DIV = 4,
    parameter int INT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             chg_i,
    input  logic [INT_W-1:0] interval_i,
    output logic             tick_o,
    output logic             step_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [INT_W-1:0] icnt_q;
    logic [INT_W-1:0] peff;
    logic             last;

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             pre_q <= '0;
                else if (clr_i)         pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                    pre_q <= pre_q + PRE_W'(1);
            end
            assign tick_o = (pre_q == PRE_LAST) && !clr_i;
        end else begin : g_nodiv
            assign tick_o = !clr_i;
        end
    endgenerate

    always_comb begin
        peff = (interval_i == '0) ? INT_W'(1) : interval_i;
        last = (icnt_q >= (peff - INT_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             icnt_q <= '0;
        else if (clr_i || chg_i) icnt_q <= '0;
        else if (tick_o)        icnt_q <= last ? '0 : icnt_q + INT_W'(1);
    end

    assign step_o = tick_o && last && !chg_i && !clr_i;

    // R1
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (icnt_q == '0) && !step_o);

    // R7
    chg_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i && !clr_i) |=> (icnt_q == '0));
endmodule

// File: rtl/dr_limit_mask.sv
module dr_limit_mask #(
    parameter int ACC_W = 32,
    parameter int KEEP  = 16
) (
    input  logic             phase_i,
    input  logic [ACC_W-1:0] hi_i,
    input  logic [ACC_W-1:0] lo_i,
    output logic [ACC_W-1:0] hi_o,
    output logic [ACC_W-1:0] lo_o
);
    generate
        if (KEEP >= ACC_W) begin : g_full
            assign hi_o = hi_i;
            assign lo_o = lo_i;
        end else begin : g_mask
            localparam logic [ACC_W-1:0] MASK = {{KEEP{1'b1}}, {(ACC_W-KEEP){1'b0}}};
            assign hi_o = phase_i ? (hi_i & MASK) : hi_i;
            assign lo_o = phase_i ? (lo_i & MASK) : lo_i;
        end
    endgenerate
endmodule

// File: rtl/dr_ramp_core.sv
module dr_ramp_core
    import dr_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             dir_up_i,
    input  logic             tick_i,
    input  logic             step_i,
    input  logic             nd_hi_i,
    input  logic             nd_lo_i,
    input  logic [ACC_W-1:0] hi_i,
    input  logic [ACC_W-1:0] lo_i,
    input  logic [ACC_W-1:0] step_up_i,
    input  logic [ACC_W-1:0] step_dn_i,
    output logic             chg_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             at_hi_o,
    output logic             at_lo_o
);
    dr_dir_e          st_q, nxt_st, dir_now;
    logic             pend_q, pend_dir_q, dir_d_q;
    logic [ACC_W-1:0] acc_q, nxt_acc;
    logic [ACC_W:0]   sum, dif;
    logic             hit_hi, hit_lo;

    assign chg_o = (dir_up_i != dir_d_q);

    always_comb begin
        if (pend_q) dir_now = pend_dir_q ? DR_RISE : DR_FALL;
        else        dir_now = st_q;
        sum     = {1'b0, acc_q} + {1'b0, step_up_i};
        dif     = {1'b0, acc_q} - {1'b0, step_dn_i};
        nxt_acc = acc_q;
        nxt_st  = dir_now;
        hit_hi  = 1'b0;
        hit_lo  = 1'b0;
        unique case (dir_now)
            DR_RISE: begin
                if (nd_hi_i && (acc_q >= hi_i)) begin
                    nxt_acc = lo_i;
                    hit_lo  = 1'b1;
                end else if (sum >= {1'b0, hi_i}) begin
                    nxt_acc = hi_i;
                    hit_hi  = 1'b1;
                    nxt_st  = nd_hi_i ? DR_RISE : DR_FALL;
                end else begin
                    nxt_acc = sum[ACC_W-1:0];
                end
            end
            DR_FALL: begin
                if (nd_lo_i && (acc_q <= lo_i)) begin
                    nxt_acc = hi_i;
                    hit_hi  = 1'b1;
                end else if (dif[ACC_W] || (dif[ACC_W-1:0] <= lo_i)) begin
                    nxt_acc = lo_i;
                    hit_lo  = 1'b1;
                    nxt_st  = nd_lo_i ? DR_FALL : DR_RISE;
                end else begin
                    nxt_acc = dif[ACC_W-1:0];
                end
            end
            default: ;
        endcase
    end

    // state register: direction state and pending request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= DR_RISE;
            pend_q     <= 1'b0;
            pend_dir_q <= 1'b0;
            dir_d_q    <= 1'b1;
        end else if (clr_i) begin
            st_q       <= dir_up_i ? DR_RISE : DR_FALL;
            pend_q     <= 1'b0;
            pend_dir_q <= dir_up_i;
            dir_d_q    <= dir_up_i;
        end else begin
            dir_d_q <= dir_up_i;
            if (chg_o) begin
                pend_q     <= 1'b1;
                pend_dir_q <= dir_up_i;
            end else if (step_i) begin
                st_q   <= nxt_st;
                pend_q <= 1'b0;
            end
        end
    end

    // outputs: accumulator and limit flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            at_hi_o <= 1'b0;
            at_lo_o <= 1'b0;
        end else if (clr_i) begin
            acc_q   <= lo_i;
            at_hi_o <= 1'b0;
            at_lo_o <= 1'b0;
        end else begin
            if (step_i) acc_q <= nxt_acc;
            if (tick_i) begin
                at_hi_o <= step_i && hit_hi;
                at_lo_o <= step_i && hit_lo;
            end
        end
    end

    assign acc_o = acc_q;

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> (acc_q == $past(acc_q)));

    // R4
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (lo_i <= hi_i) && (acc_q >= lo_i) && (acc_q <= hi_i))
        |=> (acc_q <= $past(hi_i)) && (acc_q >= $past(lo_i)));

    // R6
    snap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && (dir_now == DR_RISE) && nd_hi_i && (acc_q >= hi_i))
        |=> (acc_q == $past(lo_i)));

    // R9
    flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(at_hi_o) || $rose(at_lo_o)) |-> $past(step_i));

    // R7
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o && !clr_i) |=> pend_q);
endmodule

// File: rtl/dig_ramp_gen.sv
module dig_ramp_gen #(
    parameter int ACC_W      = 32,
    parameter int INT_W      = 16,
    parameter int TICK_DIV   = 4,
    parameter int PHASE_KEEP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dir_up,
    input  logic             dest_phase,
    input  logic             nodwell_hi,
    input  logic             nodwell_lo,
    input  logic [ACC_W-1:0] lim_hi,
    input  logic [ACC_W-1:0] lim_lo,
    input  logic [ACC_W-1:0] step_up,
    input  logic [ACC_W-1:0] step_dn,
    input  logic [INT_W-1:0] interval,
    output logic [ACC_W-1:0] ramp_out,
    output logic [ACC_W-1:0] freq_ofs,
    output logic [ACC_W-1:0] phase_ofs,
    output logic             at_hi,
    output logic             at_lo
);
    logic             tick, step, chg;
    logic [ACC_W-1:0] hi_e, lo_e, acc;

    dr_tick_gen #(.TICK_DIV(TICK_DIV), .INT_W(INT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .chg_i(chg),
        .interval_i(interval), .tick_o(tick), .step_o(step)
    );

    dr_limit_mask #(.ACC_W(ACC_W), .KEEP(PHASE_KEEP)) u_mask (
        .phase_i(dest_phase), .hi_i(lim_hi), .lo_i(lim_lo),
        .hi_o(hi_e), .lo_o(lo_e)
    );

    dr_ramp_core #(.ACC_W(ACC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .dir_up_i(dir_up),
        .tick_i(tick), .step_i(step), .nd_hi_i(nodwell_hi), .nd_lo_i(nodwell_lo),
        .hi_i(hi_e), .lo_i(lo_e), .step_up_i(step_up), .step_dn_i(step_dn),
        .chg_o(chg), .acc_o(acc), .at_hi_o(at_hi), .at_lo_o(at_lo)
    );

    assign ramp_out  = acc;
    assign freq_ofs  = dest_phase ? '0 : acc;
    assign phase_ofs = dest_phase ? acc : '0;
endmodule

// File: tb/dig_ramp_gen_test.sv
module dig_ramp_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, dir_up = 1'b1, dest_phase = 1'b0;
    logic        nodwell_hi = 1'b0, nodwell_lo = 1'b0;
    logic [31:0] lim_hi = 32'd0, lim_lo = 32'd0, step_up = 32'd0, step_dn = 32'd0;
    logic [15:0] interval = 16'd1;
    logic [31:0] ramp_out, freq_ofs, phase_ofs;
    logic        at_hi, at_lo;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dig_ramp_gen uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dir_up(dir_up), .dest_phase(dest_phase),
        .nodwell_hi(nodwell_hi), .nodwell_lo(nodwell_lo), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .step_up(step_up), .step_dn(step_dn), .interval(interval),
        .ramp_out(ramp_out), .freq_ofs(freq_ofs), .phase_ofs(phase_ofs),
        .at_hi(at_hi), .at_lo(at_lo)
    );

    // behavioural reference
    logic [31:0] m_acc;
    logic        m_up, m_pend, m_pdir, m_dprev, m_athi, m_atlo;
    int          m_pre, m_icnt;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] hie, loe;
        logic [32:0] s, d;
        logic        chg, tick, stp, goup, hh, hl;
        int          peff;
        hie = dest_phase ? (lim_hi & 32'hFFFF0000) : lim_hi;
        loe = dest_phase ? (lim_lo & 32'hFFFF0000) : lim_lo;
        if (!rst_n) begin
            m_acc = 0; m_up = 1; m_pend = 0; m_pdir = 0; m_dprev = 1;
            m_athi = 0; m_atlo = 0; m_pre = 0; m_icnt = 0;
        end else if (clr) begin
            m_acc = loe; m_up = dir_up; m_pend = 0; m_pdir = dir_up; m_dprev = dir_up;
            m_athi = 0; m_atlo = 0; m_pre = 0; m_icnt = 0;
        end else begin
            chg = (dir_up != m_dprev);
            m_dprev = dir_up;
            tick = (m_pre == 3);
            m_pre = (m_pre + 1) % 4;
            peff = (interval == 0) ? 1 : int'(interval);
            stp = tick && !chg && (m_icnt >= peff - 1);
            if (chg) begin
                m_icnt = 0; m_pend = 1; m_pdir = dir_up;
            end else if (tick) begin
                m_icnt = (m_icnt >= peff - 1) ? 0 : m_icnt + 1;
            end
            hh = 0; hl = 0;
            if (stp) begin
                goup = m_pend ? m_pdir : m_up;
                m_pend = 0;
                s = {1'b0, m_acc} + {1'b0, step_up};
                d = {1'b0, m_acc} - {1'b0, step_dn};
                if (goup) begin
                    m_up = 1;
                    if (nodwell_hi && m_acc >= hie) begin m_acc = loe; hl = 1; end
                    else if (s >= {1'b0, hie}) begin m_acc = hie; hh = 1; m_up = nodwell_hi; end
                    else m_acc = s[31:0];
                end else begin
                    m_up = 0;
                    if (nodwell_lo && m_acc <= loe) begin m_acc = hie; hh = 1; end
                    else if (d[32] || d[31:0] <= loe) begin m_acc = loe; hl = 1; m_up = !nodwell_lo; end
                    else m_acc = d[31:0];
                end
            end
            if (tick) begin m_athi = hh; m_atlo = hl; end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        check(cur_req, "ramp_out", ramp_out, m_acc);
        check(cur_req, "freq_ofs", freq_ofs, dest_phase ? 32'd0 : m_acc);
        check(cur_req, "phase_ofs", phase_ofs, dest_phase ? m_acc : 32'd0);
        check(cur_req, "at_hi", {31'd0, at_hi}, {31'd0, m_athi});
        check(cur_req, "at_lo", {31'd0, at_lo}, {31'd0, m_atlo});
    end

    task automatic cfg(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] su,
                       input logic [31:0] sd, input logic [15:0] p, input logic ndh, input logic ndl,
                       input logic ph, input logic dir);
        @(negedge clk);
        lim_lo = lo; lim_hi = hi; step_up = su; step_dn = sd; interval = p;
        nodwell_hi = ndh; nodwell_lo = ndl; dest_phase = ph; dir_up = dir;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hl_len;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "reset ramp_out", ramp_out, 32'd0);
        check("R1", "reset at_hi", {31'd0, at_hi}, 32'd0);
        rst_n = 1'b1;
        run(5);
        cfg(32'd100, 32'd1000, 32'd7, 32'd3, 16'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R1", "clear loads floor", ramp_out, 32'd100);

        cur_req = "R3"; run(400);
        cur_req = "R2";
        @(negedge clk) interval = 16'd0;
        run(200);

        cur_req = "R5";
        cfg(32'd100, 32'd1000, 32'd50, 32'd40, 16'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        run(900);

        cur_req = "R4";
        cfg(32'd0, 32'hFFFFFFF0, 32'h80000000, 32'hC0000000, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        run(120);

        cur_req = "R6";
        cfg(32'd10, 32'd100, 32'd30, 32'd25, 16'd1, 1'b1, 1'b1, 1'b0, 1'b1);
        run(300);
        cfg(32'd10, 32'd100, 32'd30, 32'd25, 16'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        run(300);

        cur_req = "R7";
        cfg(32'd0, 32'd5000, 32'd11, 32'd13, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1);
        run(57);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk) dir_up = ~dir_up;
            run(7 + 3 * k);
        end

        cur_req = "R8";
        cfg(32'h0000ABCD, 32'hFFFFFFFF, 32'h10000000, 32'h10000000, 16'd1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8", "masked floor", ramp_out, 32'd0);
        check("R8", "freq_ofs zero in phase mode", freq_ofs, 32'd0);
        while (at_hi !== 1'b1) @(negedge clk);
        check("R8", "masked ceiling", ramp_out, 32'hFFFF0000);
        cur_req = "R9";
        hl_len = 0;
        while (at_hi === 1'b1) begin hl_len++; @(negedge clk); end
        check("R9", "at_hi length", hl_len, 32'd4);
        run(300);

        cur_req = "R10";
        cfg(32'd0, 32'hF0000000, 32'h10000000, 32'hF0000000, 16'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        while (at_hi !== 1'b1) @(negedge clk);
        run(4);
        check("R10", "drop to floor", ramp_out, 32'd0);
        run(4);
        check("R10", "rise again", ramp_out, 32'h10000000);
        run(300);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule